// File: doc/BRIEF.md
# Change-Triggered Sideband Serializer

This block carries a handful of slow, asynchronous sideband control levels (suspend request, NMI, sleep, delayed sleep, ASMI and INTR) across one serial wire that runs on the bus clock. Each level is first passed through a synchronizer. The synchronized set is then compared with the set that was last sent. When they differ, the block launches a fixed 20-bit frame. The frame holds two low start bits, sixteen data slots sent LSB first, and two high stop bits. A change that arrives while a frame is shifting leaves that frame untouched. A fresh frame carrying the newest values follows directly after it.

A 2-bit mode input selects one of three behaviours. In the level mode the wire simply mirrors the synchronized suspend input. In the basic serial mode only the four power-management levels travel, and the ASMI and INTR slots are sent high. The full serial mode carries all six levels. The block also drives an SMI output, which is a software flag ORed with the active-low ASMI input. It also drives a hold output that stalls completion of inbound transactions while a frame is on the wire, provided the hold enable is set.

Top module: `sbs_serializer`

## Requirements
- R1: A change on any sideband input that alters the outgoing data word starts a frame at the third rising clock edge after the input changes. That is two synchronizer edges plus one launch edge.
- R2: A frame lasts 20 clock cycles and is sent in this order: frame bits 0 and 1 are start bits (0), frame bits 2..17 are data slots 00..15 in ascending order, and frame bits 18 and 19 are stop bits (1).
- R3: Sideband input index i (0 = suspend level, 1 = NMI#, 2 = sleep#, 3 = delayed sleep#, 4 = ASMI#, 5 = INTR#) is sent as-is in data slot 2+i. Slots 00, 01 and 08..15 are always 1.
- R4: In the basic serial mode, slots 06 and 07 are sent as 1, and a change on ASMI# or INTR# alone starts no frame.
- R5: Mode encoding is 00 = level, 01 = basic serial, 10 = full serial, and 11 = full serial.
- R6: In level mode the serial output equals the synchronized suspend input (two edges of latency), no frame is sent, and returning to a serial mode with unchanged inputs sends no frame.
- R7: A change during a frame does not alter that frame. A new frame with the latest values starts on the cycle right after the last stop bit, so two frames form one 40-cycle busy run, and several such changes merge into one follow-up frame.
- R8: In the serial modes the output idles at 1 between frames, and no frame is sent while the data word is unchanged.
- R9: After reset, the output is 1 and no frame is sent, even if the inputs differ from their reset values.
- R10: The SMI output is high when the software SMI flag is high or the synchronized ASMI# input is low.
- R11: The hold output is high exactly while a frame is in progress and the hold enable is set. It stays low when the enable is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, also the serial bit clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sbIn | input | 6 | Raw sideband levels: suspend, NMI#, sleep#, delayed sleep#, ASMI#, INTR# |
| swSmiFlag | input | 1 | Software SMI-received flag |
| modeSel | input | 2 | Mode select (00 level, 01 basic, 10/11 full) |
| holdEn | input | 1 | Enables the hold output during frames |
| serialOut | output | 1 | Serial sideband line |
| smiOut | output | 1 | Combined SMI output |
| holdOut | output | 1 | Stall for inbound transaction completion |

## Verification
The bench builds the block with its default parameters: two synchronizer stages and two start and two stop bits around sixteen data slots. This puts the exact three-edge start latency, the 20-cycle frame and the 40-cycle back-to-back run within reach of fixed cycle counts. Frames are compared in full against values predicted from the input levels and the mode. The bench also holds windows in which no frame may appear, which covers the startup, basic-mode masking and level-mode return cases.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  localparam int SB_COUNT  = 6;   // sideband levels carried
  localparam int DATA_BITS = 16;  // data slots per frame
  localparam int SLOT_BASE = 2;   // slot of sideband index 0
  localparam int SB_ASMI   = 4;   // index of the ASMI# level
  localparam int SB_INTR   = 5;   // index of the INTR# level

  typedef enum logic [1:0] {
    MODE_LEVEL    = 2'b00,
    MODE_BASIC    = 2'b01,
    MODE_FULL     = 2'b10,
    MODE_FULL_ALT = 2'b11
  } mode_e;

  typedef struct packed {
    logic load;   // latch a new frame and snapshot
    logic shift;  // advance the shift register
    logic track;  // snapshot follows the live word
  } ctrl_s;

  // Data word for the current levels; reserved and masked slots are 1.
  function automatic logic [DATA_BITS-1:0] buildWord(
      input logic [SB_COUNT-1:0] sb, input logic basic);
    logic [DATA_BITS-1:0] w;
    w = '1;
    for (int i = 0; i < SB_COUNT; i++) begin
      if (!(basic && (i == SB_ASMI || i == SB_INTR))) w[SLOT_BASE+i] = sb[i];
    end
    return w;
  endfunction

endpackage

// File: rtl/sbs_sync.sv
module sbs_sync #(
  parameter int          WIDTH     = 6,
  parameter int          STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage[k] <= RESET_VAL;
      end else if (k == 0) begin
        stage[k] <= din;
      end else begin
        stage[k] <= stage[(k == 0) ? 0 : k-1];
      end
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/sbs_datapath.sv
module sbs_datapath
  import sbs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HEAD_BITS   = 2,
  parameter int TAIL_BITS   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SB_COUNT-1:0] sbIn,
  input  logic                swSmiFlag,
  input  logic [1:0]          modeSel,
  input  ctrl_s               ctrl,
  input  logic                busy,
  output logic                diff,
  output logic                modeSerial,
  output logic                serialOut,
  output logic                smiOut
);

  localparam int FRAME_W = HEAD_BITS + DATA_BITS + TAIL_BITS;

  logic [SB_COUNT-1:0]  sbSync;
  logic [DATA_BITS-1:0] curWord;
  logic [DATA_BITS-1:0] lastSent;
  logic [FRAME_W-1:0]   frameVec;
  logic [FRAME_W-1:0]   shiftReg;
  logic                 basic;

  sbs_sync #(
    .WIDTH    (SB_COUNT),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL({SB_COUNT{1'b1}})
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (sbIn),
    .dout(sbSync)
  );

  always_comb begin
    basic      = (modeSel == MODE_BASIC);
    modeSerial = (modeSel != MODE_LEVEL);
    curWord    = buildWord(sbSync, basic);
    frameVec   = {{TAIL_BITS{1'b1}}, curWord, {HEAD_BITS{1'b0}}};
    diff       = (curWord != lastSent);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastSent <= '1;
      shiftReg <= '1;
    end else begin
      if (ctrl.load) begin
        shiftReg <= frameVec;
        lastSent <= curWord;
      end else begin
        if (ctrl.shift) shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
        if (ctrl.track) lastSent <= curWord;
      end
    end
  end

  always_comb begin
    if (modeSerial) serialOut = busy ? shiftReg[0] : 1'b1;
    else            serialOut = sbSync[0];
    smiOut = swSmiFlag | ~sbSync[SB_ASMI];
  end

endmodule

// File: rtl/sbs_control.sv
module sbs_control
  import sbs_pkg::*;
#(
  parameter int FRAME_W     = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  diff,
  input  logic  modeSerial,
  output ctrl_s ctrl,
  output logic  busy
);

  localparam int CNT_W     = $clog2(FRAME_W);
  localparam int WARM_INIT = SYNC_STAGES + 1;
  localparam int WARM_W    = $clog2(WARM_INIT + 1);

  logic [CNT_W-1:0]  bitCnt;
  logic [WARM_W-1:0] warmCnt;
  logic              warm;
  logic              lastBit;
  logic              canStart;

  always_comb begin
    warm       = (warmCnt != '0);
    lastBit    = busy && (bitCnt == CNT_W'(FRAME_W - 1));
    canStart   = !warm && modeSerial && (!busy || lastBit) && diff;
    ctrl.load  = canStart;
    ctrl.shift = busy && !lastBit;
    ctrl.track = warm || !modeSerial;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      warmCnt <= WARM_W'(WARM_INIT);
      bitCnt  <= '0;
      busy    <= 1'b0;
    end else begin
      if (warm) warmCnt <= warmCnt - 1'b1;
      if (!modeSerial) begin
        busy   <= 1'b0;
        bitCnt <= '0;
      end else if (canStart) begin
        busy   <= 1'b1;
        bitCnt <= '0;
      end else if (busy) begin
        if (lastBit) busy <= 1'b0;
        else         bitCnt <= bitCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sbs_serializer.sv
module sbs_serializer
  import sbs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HEAD_BITS   = 2,
  parameter int TAIL_BITS   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SB_COUNT-1:0] sbIn,
  input  logic                swSmiFlag,
  input  logic [1:0]          modeSel,
  input  logic                holdEn,
  output logic                serialOut,
  output logic                smiOut,
  output logic                holdOut
);

  localparam int FRAME_W = HEAD_BITS + DATA_BITS + TAIL_BITS;

  ctrl_s ctrl;
  logic  busy;
  logic  diff;
  logic  modeSerial;

  sbs_control #(
    .FRAME_W    (FRAME_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .diff      (diff),
    .modeSerial(modeSerial),
    .ctrl      (ctrl),
    .busy      (busy)
  );

  sbs_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .HEAD_BITS  (HEAD_BITS),
    .TAIL_BITS  (TAIL_BITS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sbIn      (sbIn),
    .swSmiFlag (swSmiFlag),
    .modeSel   (modeSel),
    .ctrl      (ctrl),
    .busy      (busy),
    .diff      (diff),
    .modeSerial(modeSerial),
    .serialOut (serialOut),
    .smiOut    (smiOut)
  );

  assign holdOut = holdEn & busy;

endmodule

// File: rtl/sbs_serializer_chk.sv
module sbs_serializer_chk #(
  parameter int FRAME_W = 20,
  parameter int HEAD    = 2,
  parameter int TAIL    = 2
) (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] modeSel,
  input logic       holdEn,
  input logic       swSmiFlag,
  input logic       busy,
  input logic       serialOut,
  input logic       holdOut,
  input logic       smiOut
);

  localparam int POS_W = $clog2(FRAME_W);

  logic [POS_W-1:0] pos;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              pos <= '0;
    else if (!busy)                         pos <= '0;
    else if (pos == POS_W'(FRAME_W - 1))    pos <= '0;
    else                                    pos <= pos + 1'b1;
  end

  // R2: start bits are low
  p_start_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && modeSel != 2'b00 && int'(pos) < HEAD) |-> !serialOut);

  // R2: stop bits are high
  p_stop_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && modeSel != 2'b00 && int'(pos) >= FRAME_W - TAIL) |-> serialOut);

  // R2: a busy run ends only after a whole frame
  p_frame_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && $past(modeSel) != 2'b00) |-> $past(pos) == POS_W'(FRAME_W - 1));

  // R8: idle line is high in the serial modes
  p_idle_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != 2'b00 && !busy) |-> serialOut);

  // R6: level mode runs no frame
  p_level_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b00) |=> !busy);

  // R11: no hold without the enable
  p_hold_gate_r11: assert property (@(posedge clk) disable iff (!rstN)
    !holdEn |-> !holdOut);

  // R10: software flag forces SMI
  p_smi_sw_r10: assert property (@(posedge clk) disable iff (!rstN)
    swSmiFlag |-> smiOut);

endmodule

bind sbs_serializer sbs_serializer_chk #(
  .FRAME_W(FRAME_W),
  .HEAD   (HEAD_BITS),
  .TAIL   (TAIL_BITS)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .modeSel  (modeSel),
  .holdEn   (holdEn),
  .swSmiFlag(swSmiFlag),
  .busy     (busy),
  .serialOut(serialOut),
  .holdOut  (holdOut),
  .smiOut   (smiOut)
);

// File: tb/test_sbs_serializer.sv
module test_sbs_serializer;

  localparam int CLK_PERIOD = 10;
  localparam int FRAME_W    = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] sbIn = 6'b110101;
  logic       swSmiFlag = 1'b0;
  logic [1:0] modeSel = 2'b10;
  logic       holdEn = 1'b1;
  wire        serialOut;
  wire        smiOut;
  wire        holdOut;

  int checks = 0;
  int errors = 0;
  logic [FRAME_W-1:0] expQ [$];
  logic [FRAME_W-1:0] capBits = '1;
  int capIdx = 0;
  int runLen = 0;
  int lastRun = 0;
  bit done = 0;

  sbs_serializer i_sbs_serializer (
    .clk      (clk),
    .rstN     (rstN),
    .sbIn     (sbIn),
    .swSmiFlag(swSmiFlag),
    .modeSel  (modeSel),
    .holdEn   (holdEn),
    .serialOut(serialOut),
    .smiOut   (smiOut),
    .holdOut  (holdOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected frame from the requirements (R2, R3, R4, R5)
  function automatic logic [FRAME_W-1:0] frameOf(input logic [5:0] sb, input logic [1:0] m);
    logic [FRAME_W-1:0] f;
    f = '1;
    f[0] = 1'b0;
    f[1] = 1'b0;
    for (int i = 0; i < 4; i++) f[4+i] = sb[i];
    if (m != 2'b01) begin
      f[8] = sb[4];
      f[9] = sb[5];
    end
    return f;
  endfunction

  // Monitor: collect frames while hold is high and compare with the scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (holdOut) begin
        capBits[capIdx] = serialOut;
        capIdx++;
        runLen++;
        if (capIdx == FRAME_W) begin
          capIdx = 0;
          if (expQ.size() == 0) begin
            check(1'b0, "R8", "unexpected frame", int'(capBits), 0);
          end else begin
            logic [FRAME_W-1:0] e;
            e = expQ.pop_front();
            check(capBits == e, "R2/R3", "frame contents", int'(capBits), int'(e));
          end
        end
      end else begin
        if (runLen != 0) lastRun = runLen;
        runLen = 0;
        capIdx = 0;
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setMode(input logic [1:0] m);
    @(negedge clk); #1;
    modeSel = m;
  endtask

  // Driver: apply new levels, optionally push an expected frame and check start timing (R1)
  task automatic change(input logic [5:0] v, input bit push, input bit checkStart);
    if (push) expQ.push_back(frameOf(v, modeSel));
    @(negedge clk); #1;
    sbIn = v;
    if (checkStart) begin
      tick(2);
      check(!holdOut, "R1", "no start after two edges", int'(holdOut), 0);
      tick(1);
      check(holdOut && !serialOut, "R1", "start on third edge",
            int'({holdOut, serialOut}), 2);
    end
  endtask

  task automatic waitIdle();
    int guard = 0;
    tick(3);
    while ((holdOut || expQ.size() != 0) && guard < 200) begin
      tick(1);
      guard++;
    end
    check(expQ.size() == 0, "R2", "expected frames sent", expQ.size(), 0);
    tick(3);
  endtask

  task automatic expectQuiet(input int n, input string req);
    bit seen = 0;
    repeat (n) begin
      tick(1);
      if (holdOut) seen = 1;
    end
    check(!seen, req, "no frame in window", int'(seen), 0);
  endtask

  initial begin
    logic [5:0] cur;
    logic [5:0] a;
    logic [5:0] b;
    logic [5:0] c;
    logic       oldSusp;

    // R9: reset with inputs away from their reset values
    tick(4);
    @(negedge clk); #1;
    rstN = 1'b1;
    begin
      bit bad = 0;
      repeat (12) begin
        tick(1);
        if (holdOut || !serialOut) bad = 1;
      end
      check(!bad, "R9", "quiet and high after reset", int'(bad), 0);
    end
    cur = sbIn;

    // R1 R2 R3 R11: single change in full mode
    cur = cur ^ 6'b000010;
    change(cur, 1, 1);
    waitIdle();
    check(lastRun == FRAME_W, "R2", "frame length", lastRun, FRAME_W);
    check(serialOut == 1'b1, "R8", "idle high after frame", int'(serialOut), 1);

    // R3 R10: ASMI and INTR slots live in full mode
    cur[4] = 1'b0;
    change(cur, 1, 0);
    waitIdle();
    check(smiOut == 1'b1, "R10", "SMI from ASMI", int'(smiOut), 1);
    cur[5] = 1'b0;
    change(cur, 1, 0);
    waitIdle();
    cur[5:4] = 2'b11;
    change(cur, 1, 0);
    waitIdle();
    check(smiOut == 1'b0, "R10", "SMI released", int'(smiOut), 0);

    // R7: changes during a frame merge into one follow-up frame
    a = cur ^ 6'b000100;
    change(a, 1, 1);
    tick(6);
    b = a ^ 6'b001000;
    change(b, 0, 0);
    tick(3);
    c = b ^ 6'b000001;
    change(c, 1, 0);
    waitIdle();
    check(lastRun == 2 * FRAME_W, "R7", "back-to-back run", lastRun, 2 * FRAME_W);
    cur = c;

    // R4 R5: basic mode masks ASMI and INTR
    setMode(2'b01);
    expectQuiet(5, "R5");
    cur[4] = 1'b0;
    change(cur, 0, 0);
    expectQuiet(30, "R4");
    check(smiOut == 1'b1, "R10", "SMI in basic mode", int'(smiOut), 1);
    cur[5] = 1'b0;
    change(cur, 0, 0);
    expectQuiet(30, "R4");
    cur[2] = ~cur[2];
    change(cur, 1, 1);
    waitIdle();
    cur[5:4] = 2'b11;
    change(cur, 0, 0);
    expectQuiet(30, "R4");

    // R5: code 11 behaves as full mode
    setMode(2'b11);
    expectQuiet(5, "R5");
    cur[4] = 1'b0;
    change(cur, 1, 1);
    waitIdle();
    cur[4] = 1'b1;
    change(cur, 1, 0);
    waitIdle();

    // R6: level mode mirrors suspend
    setMode(2'b00);
    tick(3);
    check(serialOut == cur[0], "R6", "line follows suspend", int'(serialOut), int'(cur[0]));
    oldSusp = cur[0];
    cur[0] = ~cur[0];
    change(cur, 0, 0);
    tick(1);
    check(serialOut == oldSusp, "R6", "one edge: old level", int'(serialOut), int'(oldSusp));
    tick(1);
    check(serialOut == cur[0], "R6", "two edges: new level", int'(serialOut), int'(cur[0]));
    cur[3] = ~cur[3];
    change(cur, 0, 0);
    expectQuiet(20, "R6");
    setMode(2'b10);
    expectQuiet(10, "R6");

    // R11: hold gated off by the enable
    @(negedge clk); #1;
    holdEn = 1'b0;
    cur[1] = ~cur[1];
    change(cur, 0, 0);
    tick(2);
    check(!holdOut, "R11", "hold low before start", int'(holdOut), 0);
    tick(1);
    check(!serialOut && !holdOut, "R11", "frame running, hold low",
          int'({serialOut, holdOut}), 0);
    expectQuiet(25, "R11");
    check(serialOut == 1'b1, "R8", "idle after unheld frame", int'(serialOut), 1);
    @(negedge clk); #1;
    holdEn = 1'b1;

    // R10: software flag
    @(negedge clk); #1;
    swSmiFlag = 1'b1;
    #1;
    check(smiOut == 1'b1, "R10", "SMI from software flag", int'(smiOut), 1);
    @(negedge clk); #1;
    swSmiFlag = 1'b0;
    #1;
    check(smiOut == 1'b0, "R10", "SMI low", int'(smiOut), 0);

    // R8: no frame while inputs hold
    expectQuiet(30, "R8");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule